// File: doc/BRIEF.md
# Dual Two-Phase Interval Timer with Watchdog

This block holds two independent down-counting timers behind a single-cycle register bus. Every period of a timer is split into two back-to-back countdowns: a low phase whose length comes from the timer's timeout register, followed by a high phase whose length comes from its pulse register. Each timer drives a level output that follows the phase and a one-cycle interrupt strobe at the end of every period. It keeps running periodically until software clears its enable bit.

Timer 0 has a second personality. When the low byte of its timeout register holds the key value 0xFF, it stops producing periods and acts as a watchdog instead. The upper 24 bits count down, and on expiry a sticky reset request is raised that only an external reset clears. Any write to a timer 0 count register while the watchdog is counting starts the count again. Software reprograms a timer by clearing its enable, writing the counts and setting the enable again. Setting the enable always restarts from the low phase with the counts just loaded.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset the control register is zero, so both timers are stopped. All five registers read zero. Both pulse outputs, both interrupts and the watchdog reset output are low.
- R2: Each register reads back the last value written. The byte addresses are: control 0x00, timer 0 timeout 0x04, timer 0 pulse 0x08, timer 1 timeout 0x0C, timer 1 pulse 0x10. Control keeps only bits 1:0 and reads zero above them. Any other address reads zero. Read data appears in the cycle after the read strobe's clock edge and holds until the next read.
- R3: Control bit 0 enables timer 0 and control bit 1 enables timer 1. A disabled timer keeps its pulse and interrupt outputs low whatever the other timer does.
- R4: With timeout count T and pulse count P, the pulse output is low for T cycles and then high for P cycles, and this repeats. The first low cycle is the cycle right after the clock edge that writes the enable bit from 0 to 1.
- R5: The interrupt is high for exactly one cycle per period: the last cycle of the high phase.
- R6: A count of zero is treated as one cycle, for either phase and for the watchdog count, so a period is never shorter than 2 cycles.
- R7: Clearing an enable bit makes that timer's pulse and interrupt low from the next cycle on. Setting it again restarts from the low phase using the register contents at that moment.
- R8: When bits 7:0 of the timer 0 timeout register equal 0xFF, timer 0 is a watchdog with count W = bits 31:8. The reset output rises W cycles after the enabling edge and stays high, even if the timer is disabled, until the external reset. While in this mode, timer 0's pulse and interrupt stay low.
- R9: A write to the timer 0 timeout or pulse register while the watchdog is counting restarts the count from that write's clock edge. The value being written is used.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_pulse | output | 2 | Phase level per timer, high in the pulse phase |
| tmr_irq | output | 2 | End-of-period strobe per timer |
| wdog_rst | output | 1 | Sticky watchdog reset request |

## Verification
The enabling write's clock edge is cycle 0's start. The pulse and interrupt of both timers are compared against an arithmetic model on every cycle after it, over a sweep of all timeout and pulse counts from 0 to 4, with the two timers running concurrently at different counts. Read data is sampled one cycle after the read edge. The disable effect is sampled in the first cycle after the write edge. The watchdog output is checked low in cycle W-1 and high in cycle W, both after the enabling edge and after a restarting register write. All sampling happens on the falling clock edge, so each check lands in one cycle that can be counted exactly.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic {
    PH_TMO = 1'b0,
    PH_PLS = 1'b1
  } phase_e;

  // Byte address layout: control, then one timeout/pulse pair per timer
  localparam int unsigned OFS_CTRL       = 0;
  localparam int unsigned OFS_TMR_BASE   = 4;
  localparam int unsigned OFS_TMR_STRIDE = 8;
  localparam int unsigned OFS_PLS_REL    = 4;

  // Watchdog key lives in the low byte of timer 0's timeout register
  localparam int unsigned KEY_W  = 8;
  localparam logic [KEY_W-1:0] WD_KEY = 8'hFF;

endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NTMR   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NTMR-1:0]                ctrl_q,
  output logic [NTMR-1:0]                ctrl_nxt,
  output logic [NTMR-1:0][DATA_W-1:0]    tmo_q,
  output logic [NTMR-1:0][DATA_W-1:0]    pls_q,
  output logic [NTMR-1:0]                tmo_hit,
  output logic [NTMR-1:0]                pls_hit
);

  logic                        ctrl_hit;
  logic [NTMR-1:0][DATA_W-1:0] tmo_d;
  logic [NTMR-1:0][DATA_W-1:0] pls_d;
  logic [DATA_W-1:0]           rd_mux;
  logic [DATA_W-1:0]           rdata_d;

  assign ctrl_hit = (bus_addr == ADDR_W'(OFS_CTRL));

  for (genvar g = 0; g < NTMR; g++) begin : g_dec
    assign tmo_hit[g] = (bus_addr == ADDR_W'(OFS_TMR_BASE + g * OFS_TMR_STRIDE));
    assign pls_hit[g] = (bus_addr == ADDR_W'(OFS_TMR_BASE + g * OFS_TMR_STRIDE + OFS_PLS_REL));
  end

  // Next-state for the register file
  always_comb begin
    ctrl_nxt = ctrl_q;
    tmo_d    = tmo_q;
    pls_d    = pls_q;
    if (bus_wr) begin
      if (ctrl_hit) ctrl_nxt = bus_wdata[NTMR-1:0];
      for (int i = 0; i < NTMR; i++) begin
        if (tmo_hit[i]) tmo_d[i] = bus_wdata;
        if (pls_hit[i]) pls_d[i] = bus_wdata;
      end
    end
  end

  // Read selection, unmapped addresses give zero
  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) rd_mux = DATA_W'(ctrl_q);
    for (int i = 0; i < NTMR; i++) begin
      if (tmo_hit[i]) rd_mux = tmo_q[i];
      if (pls_hit[i]) rd_mux = pls_q[i];
    end
  end

  assign rdata_d = bus_rd ? rd_mux : bus_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tmo_q     <= '0;
      pls_q     <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      tmo_q     <= tmo_d;
      pls_q     <= pls_d;
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/dpt_core.sv
module dpt_core
  import dpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          WD_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_nxt,
  input  logic              start,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] tmo_val,
  input  logic [DATA_W-1:0] pls_val,
  output logic              pulse_o,
  output logic              irq_o,
  output logic              wd_rst_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] at_least_one(input logic [DATA_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic              run_q, run_d;
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              wd_q, wd_d;
  logic              wd_mode;
  logic              trip;
  logic              last;
  logic [DATA_W-1:0] wd_load;
  logic [DATA_W-1:0] tmo_load;
  logic [DATA_W-1:0] pls_load;

  if (WD_EN) begin : g_wd
    assign wd_mode = (tmo_val[KEY_W-1:0] == WD_KEY);
  end else begin : g_nowd
    assign wd_mode = 1'b0;
  end

  assign wd_load  = at_least_one(DATA_W'(tmo_val[DATA_W-1:KEY_W]));
  assign tmo_load = wd_mode ? wd_load : at_least_one(tmo_val);
  assign pls_load = at_least_one(pls_val);
  assign last     = (cnt_q == ONE);

  always_comb begin
    run_d   = run_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    trip    = 1'b0;
    if (!en_nxt) begin
      run_d = 1'b0;
    end else if (start || (wd_mode && reg_wr && run_q)) begin
      run_d   = 1'b1;
      phase_d = PH_TMO;
      cnt_d   = tmo_load;
    end else if (run_q) begin
      if (!last) begin
        cnt_d = cnt_q - ONE;
      end else if (wd_mode) begin
        trip  = 1'b1;
        run_d = 1'b0;
      end else if (phase_q == PH_TMO) begin
        phase_d = PH_PLS;
        cnt_d   = pls_load;
      end else begin
        phase_d = PH_TMO;
        cnt_d   = tmo_load;
      end
    end
  end

  assign wd_d = wd_q | trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= PH_TMO;
      cnt_q   <= ONE;
      wd_q    <= 1'b0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wd_q    <= wd_d;
    end
  end

  assign pulse_o  = run_q && (phase_q == PH_PLS) && !wd_mode;
  assign irq_o    = run_q && (phase_q == PH_PLS) && last && !wd_mode;
  assign wd_rst_o = wd_q;

endmodule

// File: rtl/dpt_rst_sync.sv
module dpt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NTMR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NTMR-1:0]   tmr_pulse,
  output logic [NTMR-1:0]   tmr_irq,
  output logic              wdog_rst
);

  logic                        rst_sn;
  logic [NTMR-1:0]             ctrl_q;
  logic [NTMR-1:0]             ctrl_nxt;
  logic [NTMR-1:0][DATA_W-1:0] tmo_q;
  logic [NTMR-1:0][DATA_W-1:0] pls_q;
  logic [NTMR-1:0]             tmo_hit;
  logic [NTMR-1:0]             pls_hit;
  logic [NTMR-1:0]             wd_vec;

  dpt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  dpt_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NTMR   (NTMR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .ctrl_nxt  (ctrl_nxt),
    .tmo_q     (tmo_q),
    .pls_q     (pls_q),
    .tmo_hit   (tmo_hit),
    .pls_hit   (pls_hit)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    logic              wr_tmo;
    logic              wr_pls;
    logic [DATA_W-1:0] tmo_eff;
    logic [DATA_W-1:0] pls_eff;

    // A write in flight is forwarded so a restart sees the new count
    assign wr_tmo  = bus_wr && tmo_hit[g];
    assign wr_pls  = bus_wr && pls_hit[g];
    assign tmo_eff = wr_tmo ? bus_wdata : tmo_q[g];
    assign pls_eff = wr_pls ? bus_wdata : pls_q[g];

    dpt_core #(
      .DATA_W (DATA_W),
      .WD_EN  (g == 0)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_sn),
      .en_nxt   (ctrl_nxt[g]),
      .start    (ctrl_nxt[g] && !ctrl_q[g]),
      .reg_wr   (wr_tmo || wr_pls),
      .tmo_val  (tmo_eff),
      .pls_val  (pls_eff),
      .pulse_o  (tmr_pulse[g]),
      .irq_o    (tmr_irq[g]),
      .wd_rst_o (wd_vec[g])
    );
  end

  assign wdog_rst = |wd_vec;

endmodule

// File: rtl/dual_phase_timer_chk.sv
module dual_phase_timer_chk #(
  parameter int unsigned NTMR = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTMR-1:0] ctrl_q,
  input logic [NTMR-1:0] pulse,
  input logic [NTMR-1:0] irq,
  input logic            wdog
);

  for (genvar g = 0; g < NTMR; g++) begin : g_chk
    // R7: a cleared enable keeps the timer quiet
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[g] |-> (!pulse[g] && !irq[g]));

    // R5: the end-of-period strobe lasts one cycle
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> !irq[g]);

    // R5: the strobe falls inside the high phase
    a_r5_irq_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> pulse[g]);

    // R4: after a period ends the output returns to the low phase
    a_r4_low_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> !pulse[g]);
  end

  // R8: the watchdog request is sticky
  a_r8_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |=> wdog);

endmodule

bind dual_phase_timer dual_phase_timer_chk #(.NTMR(NTMR)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sn),
  .ctrl_q (ctrl_q),
  .pulse  (tmr_pulse),
  .irq    (tmr_irq),
  .wdog   (wdog_rst)
);

// File: tb/sim_dual_phase_timer.sv
`timescale 1ns/1ps
module sim_dual_phase_timer;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_T0T  = 8'h04;
  localparam logic [7:0] A_T0P  = 8'h08;
  localparam logic [7:0] A_T1T  = 8'h0C;
  localparam logic [7:0] A_T1P  = 8'h10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_pulse;
  logic [1:0]  tmr_irq;
  logic        wdog_rst;

  int n_run;
  int n_fail;

  dual_phase_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_pulse (tmr_pulse),
    .tmr_irq   (tmr_irq),
    .wdog_rst  (wdog_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {pulse, irq} expected c cycles after the enabling edge
  function automatic logic [1:0] exp_out(input int t, input int p, input int c);
    int te = (t == 0) ? 1 : t;
    int pe = (p == 0) ? 1 : p;
    int m  = c % (te + pe);
    return {m >= te, m == te + pe - 1};
  endfunction

  task automatic run_pair(input string tag, input int t0, input int p0,
                          input int t1, input int p1, input logic [1:0] en,
                          input int ncyc);
    logic [1:0] af [2];
    logic [1:0] ef [2];
    bit         bad [2];
    bus_write(A_CTRL, 32'h0);
    bus_write(A_T0T, t0);
    bus_write(A_T0P, p0);
    bus_write(A_T1T, t1);
    bus_write(A_T1P, p1);
    bus_write(A_CTRL, {30'b0, en});
    for (int k = 0; k < 2; k++) begin
      bad[k] = 1'b0; af[k] = 2'b00; ef[k] = 2'b00;
    end
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < 2; k++) begin
        int tt = (k == 1) ? t1 : t0;
        int pp = (k == 1) ? p1 : p0;
        logic [1:0] e = en[k] ? exp_out(tt, pp, c) : 2'b00;
        logic [1:0] a = {tmr_pulse[k], tmr_irq[k]};
        if (a !== e && !bad[k]) begin
          bad[k] = 1'b1; af[k] = a; ef[k] = e;
          $display("  mismatch %s timer%0d cycle %0d", tag, k, c);
        end
      end
      @(negedge clk);
    end
    chk({tag, " timer0"}, {30'b0, af[0]}, {30'b0, ef[0]});
    chk({tag, " timer1"}, {30'b0, af[1]}, {30'b0, ef[1]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          bad;
    n_run = 0; n_fail = 0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1: reset state
    chk("R1 outputs", {27'b0, tmr_pulse, tmr_irq, wdog_rst}, 32'h0);
    bus_read(A_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
    bus_read(A_T0T, rd);  chk("R1 t0 timeout", rd, 32'h0);
    bus_read(A_T1P, rd);  chk("R1 t1 pulse", rd, 32'h0);

    // R2: readback and decode
    bus_write(A_T0T, 32'hA5A5_0102);
    bus_write(A_T0P, 32'h1234_5678);
    bus_write(A_T1T, 32'h0BAD_F00D);
    bus_write(A_T1P, 32'hCAFE_0001);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(A_CTRL, 32'hFFFF_FFFC);
    bus_read(A_T0T, rd);  chk("R2 t0 timeout", rd, 32'hA5A5_0102);
    bus_read(A_T0P, rd);  chk("R2 t0 pulse", rd, 32'h1234_5678);
    bus_read(A_T1T, rd);  chk("R2 t1 timeout", rd, 32'h0BAD_F00D);
    bus_read(A_T1P, rd);  chk("R2 t1 pulse", rd, 32'hCAFE_0001);
    bus_read(A_CTRL, rd); chk("R2 ctrl upper bits", rd, 32'h0);
    bus_read(8'h14, rd);  chk("R2 unmapped", rd, 32'h0);
    @(negedge clk);
    chk("R2 rdata holds", bus_rdata, 32'h0);

    // R4 R5 R6: full sweep of small counts, both timers concurrently
    for (int t = 0; t < 5; t++) begin
      for (int p = 0; p < 5; p++) begin
        run_pair($sformatf("R4 R5 R6 T=%0d P=%0d", t, p), p + 1, t + 2, t, p, 2'b11, 40);
      end
    end

    // R3: enables are independent
    run_pair("R3 only timer0", 2, 3, 1, 1, 2'b01, 30);
    run_pair("R3 only timer1", 1, 1, 4, 2, 2'b10, 30);

    // R7: disable mid high phase, then restart with fresh counts
    bus_write(A_CTRL, 32'h0);
    bus_write(A_T1T, 32'd3);
    bus_write(A_T1P, 32'd3);
    bus_write(A_CTRL, 32'h2);
    repeat (4) @(negedge clk);
    chk("R7 high before disable", {31'b0, tmr_pulse[1]}, 32'h1);
    bus_write(A_CTRL, 32'h0);
    bad = 0;
    for (int c = 0; c < 8; c++) begin
      if (tmr_pulse[1] !== 1'b0 || tmr_irq[1] !== 1'b0) bad++;
      @(negedge clk);
    end
    chk("R7 quiet after disable", bad, 0);
    run_pair("R7 restart fresh counts", 1, 1, 2, 5, 2'b10, 21);

    // R8: watchdog mode expiry and stickiness
    bus_write(A_CTRL, 32'h0);
    bus_write(A_T0T, (32'd20 << 8) | 32'hFF);
    bus_write(A_CTRL, 32'h1);
    bad = 0;
    for (int c = 0; c < 20; c++) begin
      if (wdog_rst !== 1'b0 || tmr_pulse[0] !== 1'b0 || tmr_irq[0] !== 1'b0) bad++;
      @(negedge clk);
    end
    chk("R8 low until cycle W-1, timer0 quiet", bad, 0);
    chk("R8 high at cycle W", {31'b0, wdog_rst}, 32'h1);
    bus_write(A_CTRL, 32'h0);
    repeat (5) @(negedge clk);
    chk("R8 sticky after disable", {31'b0, wdog_rst}, 32'h1);
    do_reset();
    chk("R1 reset clears watchdog", {31'b0, wdog_rst}, 32'h0);

    // R9: register write restarts the watchdog count
    bus_write(A_T0T, (32'd20 << 8) | 32'hFF);
    bus_write(A_CTRL, 32'h1);
    repeat (9) @(negedge clk);
    bus_write(A_T0P, 32'h77);
    repeat (19) @(negedge clk);
    chk("R9 still low after restart", {31'b0, wdog_rst}, 32'h0);
    @(negedge clk);
    chk("R9 high W cycles after restart", {31'b0, wdog_rst}, 32'h1);
    do_reset();

    // R6: zero watchdog count is one cycle
    bus_write(A_T0T, 32'h0000_00FF);
    bus_write(A_CTRL, 32'h1);
    chk("R6 watchdog zero count cycle 0", {31'b0, wdog_rst}, 32'h0);
    @(negedge clk);
    chk("R6 watchdog zero count cycle 1", {31'b0, wdog_rst}, 32'h1);
    do_reset();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule